// File: doc/BRIEF.md
# Tag check fault reporter

This block sits beside the load/store path and decides, for one memory access per cycle, whether the four tag bits carried in the pointer's top byte agree with the tag stored for the addressed granule. Accesses that are unchecked pass without a comparison. These are accesses where top-byte-ignore is off for the selected half of the address space, where the page has no tag storage, or where a match-all bypass is active. A checked access passes only on an exact tag match.

On a mismatch the block reads a 2-bit fault mode from a 64-bit system control word. Which pair of bits it reads depends on whether the access runs in a user-level regime. Depending on that mode, the failure is silent, raises a synchronous abort request with syndrome and fault address, sets a sticky asynchronous status bit, or raises a one-cycle configuration-error pulse. The sticky bits are kept for each exception level, two per level. They build up by OR across faults and are cleared only through a dedicated clear port.

The verdict and every pulse appear one clock after the request. Tag memory lookup and exception vectoring are handled elsewhere.

Top module: `tagchk_fault_unit`

## Requirements
- R1: When `tbi_en[req_ptr[55]]` is 0, the access is unchecked: `rsp_pass` is 1 and no fault action occurs.
- R2: When `tags_present` is 0 or `match_all` is 1, the access passes without comparison.
- R3: A checked access passes only when `req_ptr[59:56]` equals `mem_tag`.
- R4: `rsp_valid` is a one-cycle pulse exactly one clock after each `req_valid` cycle. `rsp_pass`, `abort_req` and `cfg_err` can be 1 only while `rsp_valid` is 1.
- R5: The fault mode is `ctrl_word[39:38]` when `user_regime` is 1, and `ctrl_word[41:40]` otherwise. Mode values: 0 silent, 1 synchronous, 2 asynchronous, 3 reserved.
- R6: A failed check in mode 1 pulses `abort_req`. It loads `abort_syndrome` with {`!user_regime`, 6'h11}, where bit 6 marks a non-user regime and bits [5:0] hold the fault status code. It loads `abort_addr` with the whole pointer, tag bits included. Both hold until the next abort.
- R7: A failed check in mode 2 sets status bit `2*L + B` of `async_status`. L is 0 for user regimes and `req_el` otherwise. B is `req_ptr[55]` when `two_ranges` is 1, and 0 otherwise.
- R8: A failed check in mode 3 pulses `cfg_err` only. There is no abort and no status change.
- R9: A failed check in mode 0 gives `rsp_pass` = 0 with no abort, no status change and no `cfg_err`.
- R10: Status bits accumulate by OR and never clear on their own. A `clear_valid` cycle clears the bits of level `clear_lvl` that are set in `clear_mask` (bit 0 of the mask clears B = 0, bit 1 clears B = 1). A fault that sets a bit in the same cycle wins over the clear.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access check request |
| req_ptr | input | 64 | Pointer with tag in bits [59:56] |
| mem_tag | input | 4 | Stored tag of the addressed granule |
| tags_present | input | 1 | Page has tag storage |
| tbi_en | input | 2 | Top-byte-ignore enable for each address half, indexed by pointer bit 55 |
| match_all | input | 1 | Bypass: treat the access as matching |
| req_el | input | 2 | Exception level of the access |
| user_regime | input | 1 | Access runs in a user-level regime |
| two_ranges | input | 1 | Regime has two address ranges |
| ctrl_word | input | 64 | System control word holding both fault mode fields |
| clear_valid | input | 1 | Clear strobe for sticky status |
| clear_lvl | input | 2 | Level whose status bits are cleared |
| clear_mask | input | 2 | Which of the level's two bits to clear |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_pass | output | 1 | Access passed the check |
| abort_req | output | 1 | Synchronous abort request pulse |
| abort_syndrome | output | 7 | Privilege bit and fault status code of the last abort |
| abort_addr | output | 64 | Faulting pointer of the last abort |
| async_status | output | 8 | Sticky asynchronous status, two bits per level |
| cfg_err | output | 1 | Reserved fault mode pulse |

## Verification
The bench builds the block with its defaults: a 4-bit tag, four exception levels and the fault fields at bits 38 and 40. These keep the tag space small enough to sweep every pointer-tag and stored-tag pair. They also allow every combination of both mode fields, regime class, level, range count and pointer bit 55, so each of the eight status bits is reached by arithmetic prediction. The bypass inputs are swept in every combination over both halves of the address space. Clear-port cases cover partial masks and a clear that lands in the same cycle as a new fault.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    typedef enum logic [1:0] {
        FM_SILENT = 2'd0,
        FM_SYNC   = 2'd1,
        FM_ASYNC  = 2'd2,
        FM_RSVD   = 2'd3
    } fault_mode_e;

    localparam int unsigned FSC_W = 6;
    localparam logic [FSC_W-1:0] FSC_TAG_FAIL = 6'h11;

endpackage

// File: rtl/tagchk_compare.sv
module tagchk_compare #(
    parameter int unsigned TAG_W = 4
) (
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic             ptr_half,
    input  logic [TAG_W-1:0] mem_tag,
    input  logic             tags_present,
    input  logic             match_all,
    input  logic [1:0]       tbi_en,
    output logic             tag_ok
);
    logic checked;

    // The top byte of the selected half must be ignored for a check to apply.
    always_comb begin
        checked = tbi_en[ptr_half] && tags_present && !match_all;
        tag_ok  = !checked || (ptr_tag == mem_tag);
    end
endmodule

// File: rtl/tagchk_mode_sel.sv
module tagchk_mode_sel
    import tagchk_pkg::*;
(
    input  logic [1:0]  user_field,
    input  logic [1:0]  priv_field,
    input  logic        user_regime,
    output fault_mode_e mode
);
    always_comb begin
        mode = fault_mode_e'(user_regime ? user_field : priv_field);
    end
endmodule

// File: rtl/tagchk_sticky.sv
module tagchk_sticky #(
    parameter int unsigned NUM_LVL = 4,
    localparam int unsigned LVL_W = $clog2(NUM_LVL),
    localparam int unsigned ST_W  = 2 * NUM_LVL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [LVL_W-1:0] set_lvl,
    input  logic             set_idx,
    input  logic             clr_en,
    input  logic [LVL_W-1:0] clr_lvl,
    input  logic [1:0]       clr_mask,
    output logic [ST_W-1:0]  status
);
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic [1:0] bits_d;
        logic [1:0] bits_q;

        always_comb begin
            bits_d = bits_q;
            if (clr_en && clr_lvl == LVL_W'(g)) begin
                bits_d = bits_d & ~clr_mask;
            end
            if (set_en && set_lvl == LVL_W'(g)) begin
                bits_d[set_idx] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else begin
                bits_q <= bits_d;
            end
        end

        assign status[2*g +: 2] = bits_q;
    end
endmodule

// File: rtl/tagchk_fault_unit.sv
module tagchk_fault_unit
    import tagchk_pkg::*;
#(
    parameter int unsigned PTR_W     = 64,
    parameter int unsigned TAG_W     = 4,
    parameter int unsigned TAG_LSB   = 56,
    parameter int unsigned HALF_BIT  = 55,
    parameter int unsigned CTRL_W    = 64,
    parameter int unsigned USER_LSB  = 38,
    parameter int unsigned PRIV_LSB  = 40,
    parameter int unsigned NUM_LVL   = 4,
    localparam int unsigned LVL_W    = $clog2(NUM_LVL),
    localparam int unsigned ST_W     = 2 * NUM_LVL,
    localparam int unsigned SYN_W    = FSC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PTR_W-1:0]  req_ptr,
    input  logic [TAG_W-1:0]  mem_tag,
    input  logic              tags_present,
    input  logic [1:0]        tbi_en,
    input  logic              match_all,
    input  logic [LVL_W-1:0]  req_el,
    input  logic              user_regime,
    input  logic              two_ranges,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              clear_valid,
    input  logic [LVL_W-1:0]  clear_lvl,
    input  logic [1:0]        clear_mask,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic              abort_req,
    output logic [SYN_W-1:0]  abort_syndrome,
    output logic [PTR_W-1:0]  abort_addr,
    output logic [ST_W-1:0]   async_status,
    output logic              cfg_err
);
    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_pass;
        logic             abort;
        logic [SYN_W-1:0] syn;
        logic [PTR_W-1:0] addr;
        logic             cfg_err;
    } verdict_t;

    verdict_t         vd_d;
    verdict_t         vd_q;
    logic             tag_ok;
    fault_mode_e      mode;
    logic             set_en;
    logic [LVL_W-1:0] set_lvl;
    logic             set_idx;
    logic             unused_ctrl;

    // Only the two mode fields of the control word matter here.
    assign unused_ctrl = ^ctrl_word;

    tagchk_compare #(
        .TAG_W(TAG_W)
    ) u_cmp (
        .ptr_tag     (req_ptr[TAG_LSB +: TAG_W]),
        .ptr_half    (req_ptr[HALF_BIT]),
        .mem_tag     (mem_tag),
        .tags_present(tags_present),
        .match_all   (match_all),
        .tbi_en      (tbi_en),
        .tag_ok      (tag_ok)
    );

    tagchk_mode_sel u_mode (
        .user_field (ctrl_word[USER_LSB +: 2]),
        .priv_field (ctrl_word[PRIV_LSB +: 2]),
        .user_regime(user_regime),
        .mode       (mode)
    );

    always_comb begin
        vd_d           = vd_q;
        vd_d.rsp_valid = req_valid;
        vd_d.rsp_pass  = 1'b0;
        vd_d.abort     = 1'b0;
        vd_d.cfg_err   = 1'b0;
        set_en         = 1'b0;
        set_lvl        = user_regime ? '0 : req_el;
        set_idx        = two_ranges ? req_ptr[HALF_BIT] : 1'b0;
        if (req_valid) begin
            vd_d.rsp_pass = tag_ok;
            if (!tag_ok) begin
                unique case (mode)
                    FM_SYNC: begin
                        vd_d.abort = 1'b1;
                        vd_d.syn   = {!user_regime, FSC_TAG_FAIL};
                        vd_d.addr  = req_ptr;
                    end
                    FM_ASYNC: set_en       = 1'b1;
                    FM_RSVD:  vd_d.cfg_err = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    tagchk_sticky #(
        .NUM_LVL(NUM_LVL)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_lvl (set_lvl),
        .set_idx (set_idx),
        .clr_en  (clear_valid),
        .clr_lvl (clear_lvl),
        .clr_mask(clear_mask),
        .status  (async_status)
    );

    assign rsp_valid      = vd_q.rsp_valid;
    assign rsp_pass       = vd_q.rsp_pass;
    assign abort_req      = vd_q.abort;
    assign abort_syndrome = vd_q.syn;
    assign abort_addr     = vd_q.addr;
    assign cfg_err        = vd_q.cfg_err;
endmodule

// File: rtl/tagchk_fault_unit_chk.sv
module tagchk_fault_unit_chk #(
    parameter int unsigned PTR_W = 64,
    parameter int unsigned SYN_W = 7,
    parameter int unsigned ST_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PTR_W-1:0] req_ptr,
    input logic             clear_valid,
    input logic             rsp_valid,
    input logic             rsp_pass,
    input logic             abort_req,
    input logic [SYN_W-1:0] abort_syndrome,
    input logic [PTR_W-1:0] abort_addr,
    input logic [ST_W-1:0]  async_status,
    input logic             cfg_err
);
    p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_outputs_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pass || abort_req || cfg_err) |-> rsp_valid);

    p_pass_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pass |-> (!abort_req && !cfg_err));

    p_abort_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (abort_syndrome[SYN_W-2:0] == 6'h11));

    p_abort_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (abort_addr == $past(req_ptr)));

    p_rsvd_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_req && cfg_err));

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_valid |=> ((async_status & $past(async_status)) == $past(async_status)));
endmodule

bind tagchk_fault_unit tagchk_fault_unit_chk #(
    .PTR_W(PTR_W),
    .SYN_W(SYN_W),
    .ST_W (ST_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ptr       (req_ptr),
    .clear_valid   (clear_valid),
    .rsp_valid     (rsp_valid),
    .rsp_pass      (rsp_pass),
    .abort_req     (abort_req),
    .abort_syndrome(abort_syndrome),
    .abort_addr    (abort_addr),
    .async_status  (async_status),
    .cfg_err       (cfg_err)
);

// File: tb/tagchk_fault_unit_test.sv
`timescale 1ns/1ps
module tagchk_fault_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [3:0]  mem_tag = '0;
    logic        tags_present = 1'b0;
    logic [1:0]  tbi_en = '0;
    logic        match_all = 1'b0;
    logic [1:0]  req_el = '0;
    logic        user_regime = 1'b0;
    logic        two_ranges = 1'b0;
    logic [63:0] ctrl_word = '0;
    logic        clear_valid = 1'b0;
    logic [1:0]  clear_lvl = '0;
    logic [1:0]  clear_mask = '0;
    logic        rsp_valid;
    logic        rsp_pass;
    logic        abort_req;
    logic [6:0]  abort_syndrome;
    logic [63:0] abort_addr;
    logic [7:0]  async_status;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    logic [7:0]  exp_stat = '0;
    logic [63:0] exp_addr = '0;
    logic [6:0]  exp_syn = '0;

    always #2 clk = ~clk;

    tagchk_fault_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
        .mem_tag(mem_tag), .tags_present(tags_present), .tbi_en(tbi_en),
        .match_all(match_all), .req_el(req_el), .user_regime(user_regime),
        .two_ranges(two_ranges), .ctrl_word(ctrl_word), .clear_valid(clear_valid),
        .clear_lvl(clear_lvl), .clear_mask(clear_mask), .rsp_valid(rsp_valid),
        .rsp_pass(rsp_pass), .abort_req(abort_req), .abort_syndrome(abort_syndrome),
        .abort_addr(abort_addr), .async_status(async_status), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [63:0] mk_ctrl(input int mu, input int mp);
        logic [63:0] c;
        c = 64'h5A00_0000_0000_F00F;
        c[39:38] = 2'(mu);
        c[41:40] = 2'(mp);
        return c;
    endfunction

    // Drive one request at a falling edge; results are registered at the next
    // rising edge and sampled at the falling edge after that.
    task automatic send(input logic [63:0] p, input logic [3:0] mt, input logic pres,
                        input logic mall, input logic [1:0] tbi, input logic [1:0] el,
                        input logic usr, input logic two, input logic [63:0] cw);
        @(negedge clk);
        req_valid = 1'b1; req_ptr = p; mem_tag = mt; tags_present = pres;
        match_all = mall; tbi_en = tbi; req_el = el; user_regime = usr;
        two_ranges = two; ctrl_word = cw;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        eq("R11 rsp_valid", 64'(rsp_valid), 0);
        eq("R11 rsp_pass", 64'(rsp_pass), 0);
        eq("R11 abort", 64'(abort_req), 0);
        eq("R11 addr", abort_addr, 0);
        eq("R11 status", 64'(async_status), 0);
        eq("R11 cfg_err", 64'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        eq("R4 idle", 64'(rsp_valid), 0);

        // R3 / R9: every tag pair, checked, mode 0 everywhere
        for (int pt = 0; pt < 16; pt++) begin
            for (int mt = 0; mt < 16; mt++) begin
                logic [63:0] p;
                p = 64'h0012_3456_789A_BCDE;
                p[59:56] = 4'(pt);
                p[55] = 1'((pt ^ mt) & 1);
                send(p, 4'(mt), 1'b1, 1'b0, 2'b11, 2'(mt & 3), 1'((mt >> 2) & 1),
                     1'b1, mk_ctrl(0, 0));
                eq("R4 rsp_valid", 64'(rsp_valid), 1);
                eq("R3 pass", 64'(rsp_pass), 64'(pt == mt));
                eq("R9 no abort", 64'(abort_req), 0);
                eq("R9 no cfg_err", 64'(cfg_err), 0);
            end
        end
        @(negedge clk);
        eq("R4 pulse ends", 64'(rsp_valid), 0);
        eq("R9 status untouched", 64'(async_status), 0);

        // R1 / R2: bypass inputs, tags mismatch, synchronous mode in both fields
        for (int b = 0; b < 2; b++) begin
            for (int t = 0; t < 4; t++) begin
                for (int pr = 0; pr < 2; pr++) begin
                    for (int ma = 0; ma < 2; ma++) begin
                        logic [63:0] p;
                        logic exp_pass;
                        p = 64'hF500_0000_0000_1000;
                        p[55] = 1'(b);
                        exp_pass = !(((t >> b) & 1) == 1 && pr == 1 && ma == 0);
                        send(p, 4'hA, 1'(pr), 1'(ma), 2'(t), 2'd1, 1'b0, 1'b0,
                             mk_ctrl(1, 1));
                        eq("R1/R2 pass", 64'(rsp_pass), 64'(exp_pass));
                        eq("R1/R2 abort", 64'(abort_req), 64'(!exp_pass));
                        if (!exp_pass) begin
                            exp_addr = p;
                            exp_syn = {1'b1, 6'h11};
                        end
                        eq("R6 addr hold", abort_addr, exp_addr);
                    end
                end
            end
        end

        // R5..R9: mode fields, regime, level, range count and half bit
        for (int mu = 0; mu < 4; mu++)
        for (int mp = 0; mp < 4; mp++)
        for (int us = 0; us < 2; us++)
        for (int el = 0; el < 4; el++)
        for (int tw = 0; tw < 2; tw++)
        for (int b = 0; b < 2; b++) begin
            logic [63:0] p;
            int md;
            int lvl;
            int idx;
            p = {4'hE, 4'h3, 56'(64'h9E37_79B9 * (mu * 64 + mp * 16 + el * 4 + tw * 2 + us))};
            p[55] = 1'(b);
            md = (us == 1) ? mu : mp;
            send(p, 4'hC, 1'b1, 1'b0, 2'b11, 2'(el), 1'(us), 1'(tw), mk_ctrl(mu, mp));
            eq("R3 mismatch", 64'(rsp_pass), 0);
            eq("R5/R6 abort", 64'(abort_req), 64'(md == 1));
            eq("R5/R8 cfg_err", 64'(cfg_err), 64'(md == 3));
            if (md == 1) begin
                exp_addr = p;
                exp_syn = {1'(us == 0), 6'h11};
            end
            eq("R6 syndrome", 64'(abort_syndrome), 64'(exp_syn));
            eq("R6 addr", abort_addr, exp_addr);
            if (md == 2) begin
                lvl = (us == 1) ? 0 : el;
                idx = (tw == 1) ? b : 0;
                exp_stat[2 * lvl + idx] = 1'b1;
            end
            eq("R7 status", 64'(async_status), 64'(exp_stat));
        end
        eq("R7 all bits reached", 64'(async_status), 64'hFF);

        // R10: partial clears per level
        for (int l = 0; l < 4; l++) begin
            @(negedge clk);
            clear_valid = 1'b1; clear_lvl = 2'(l); clear_mask = 2'b01;
            @(negedge clk);
            clear_valid = 1'b0;
            exp_stat[2 * l] = 1'b0;
            eq("R10 partial clear", 64'(async_status), 64'(exp_stat));
        end
        @(negedge clk);
        clear_valid = 1'b1; clear_lvl = 2'd2; clear_mask = 2'b11;
        @(negedge clk);
        clear_valid = 1'b0;
        exp_stat[5:4] = 2'b00;
        eq("R10 full clear", 64'(async_status), 64'(exp_stat));

        // R10: set wins over clear in the same cycle (level 2, bit 1)
        @(negedge clk);
        req_valid = 1'b1; req_ptr = 64'h0180_0000_0000_0040; mem_tag = 4'h0;
        tags_present = 1'b1; match_all = 1'b0; tbi_en = 2'b11; req_el = 2'd2;
        user_regime = 1'b0; two_ranges = 1'b1; ctrl_word = mk_ctrl(0, 2);
        clear_valid = 1'b1; clear_lvl = 2'd2; clear_mask = 2'b11;
        @(negedge clk);
        req_valid = 1'b0; clear_valid = 1'b0;
        exp_stat[5] = 1'b1;
        eq("R10 set beats clear", 64'(async_status), 64'(exp_stat));

        // R10: accumulate, second fault on other bit of level 2
        send(64'h0100_0000_0000_0040, 4'h0, 1'b1, 1'b0, 2'b11, 2'd2, 1'b0, 1'b1,
             mk_ctrl(0, 2));
        exp_stat[4] = 1'b1;
        eq("R10 accumulate", 64'(async_status), 64'(exp_stat));

        // R8: reserved mode leaves status and abort state untouched
        send(64'h0780_0000_0000_0000, 4'h1, 1'b1, 1'b0, 2'b11, 2'd3, 1'b0, 1'b1,
             mk_ctrl(0, 3));
        eq("R8 pulse", 64'(cfg_err), 1);
        eq("R8 status", 64'(async_status), 64'(exp_stat));
        eq("R8 addr", abort_addr, exp_addr);
        @(negedge clk);
        eq("R4 cfg_err one cycle", 64'(cfg_err), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule